// File: doc/BRIEF.md
# DC-Balance Lane Encoder

This block sits on the transmit side of a parallel-to-serial link that may be AC-coupled. One instance serves one data lane. For each 7-bit word it picks one of two forms: the word as given or its bitwise complement. The choice steers a running +1/−1 tally of the transmitted bits back toward zero. The encoder then brackets the chosen form with two complementary marker bits, so the receiver can undo any inversion. The 9-bit frame leaves one bit per clock.

The same instance also drives a companion clock lane. In every frame that lane is high for the first four or five bit periods and low for the rest. The two lengths alternate from frame to frame, so the clock lane carries no net DC component. A signed monitor output shows the running tally of the data lane.

A word is offered by pulsing a strobe for one clock. The strobe is taken when the lane is idle, or in the last bit period of a frame, which gives gap-free back-to-back frames. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `dcb_lane_enc`

## Requirements
- R1: While reset is active, and in the cycles after its release before any word is taken, `ser_out` and `clk_lane_out` are 0 and `run_sum` is 0.
- R2: A frame is sent in this order:
  - marker A;
  - the 7 payload bits, index 6 first and index 0 last;
  - marker B.

  Marker B is always the complement of marker A. Marker A is 1 exactly when the payload is the complement of the offered word.
- R3: Let S be the tally at the frame boundary. The word is complemented when S > 0 and the word has more ones than zeros, or when S < 0 and it has more zeros than ones. When S = 0 the word is sent unchanged.
- R4: Each transmitted 1 adds +1 to the tally and each transmitted 0 adds −1. All 9 frame bits count, markers included. `run_sum` includes every bit shown on `ser_out` in earlier cycles. It therefore changes by exactly ±1 at each clock edge that ends a bit period.
- R5: At every frame boundary |S| ≤ 7. At every bit the tally stays within ±11.
- R6: A strobe is taken only when the lane is idle or in the ninth bit period of a frame. Once taken, marker A appears in the next cycle, with no gap after the previous frame. A strobe in any other cycle has no effect on the outputs.
- R7: In each frame `clk_lane_out` is high for the first 4 or 5 bit periods and low for the remainder. The first frame after reset uses 4. The length alternates with every frame, including across idle gaps. The clock-lane tally therefore stays within ±5.
- R8: While no frame is in progress, `ser_out` and `clk_lane_out` are 0 and `run_sum` holds its value.
- R9: A receiver can recover every offered word exactly by complementing the payload whenever marker A is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| word_stb | input | 1 | One-cycle pulse offering `word_data` |
| word_data | input | 7 | Word to encode |
| ser_out | output | 1 | Serial data lane bit |
| clk_lane_out | output | 1 | Companion clock-lane bit |
| run_sum | output | 6 | Signed running tally of transmitted data bits |

## Verification
The bench targets the tally peak of +11. That peak is reached by an all-ones word followed by a word whose complement begins with three ones. A design that updated the tally without the markers, or that inverted on the wrong sign, lands on a different peak or a different marker bit. The bench checks that a zero tally leaves the word unchanged; the usual mistake here is to invert by default. It pulses the strobe in the middle of a frame: a design that restarts on that strobe emits a corrupted frame. It also checks that the clock-lane length keeps alternating across an idle gap; a design that resets the alternation on idle would repeat the four-bit form. A long random stream is then decoded from the serial output and compared word by word.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  // Which high length the clock lane uses for a frame
  typedef enum logic {
    HI_SHORT_SEL = 1'b0,
    HI_LONG_SEL  = 1'b1
  } hi_sel_e;

endpackage

// File: rtl/dcb_word_enc.sv
module dcb_word_enc #(
  parameter int DATA_W = 7,
  parameter int SUM_W  = 6
) (
  input  logic [DATA_W-1:0]       data,
  input  logic signed [SUM_W-1:0] bnd_sum,
  output logic [DATA_W+1:0]       frame,
  output logic                    inverted
);
  localparam int FRAME_W = DATA_W + 2;

  int   ones;
  logic more_ones;

  always_comb begin
    ones = 0;
    for (int i = 0; i < DATA_W; i++) begin
      ones = ones + int'(data[i]);
    end
  end

  assign more_ones = (2 * ones) > DATA_W;

  // Steer the tally toward zero; a zero tally leaves the word untouched
  assign inverted = ((bnd_sum > 0) && more_ones) || ((bnd_sum < 0) && !more_ones);

  // Marker A leads, payload MSB first, marker B trails
  assign frame = {inverted, (inverted ? ~data : data), ~inverted};

endmodule

// File: rtl/dcb_disparity_acc.sv
module dcb_disparity_acc #(
  parameter int DATA_W = 7,
  parameter int SUM_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_valid,
  input  logic                    bit_val,
  input  logic                    boundary,
  output logic signed [SUM_W-1:0] sum,
  output logic signed [SUM_W-1:0] sum_next
);
  localparam int BND_LIM = DATA_W;
  localparam int BIT_LIM = DATA_W + 1 + (DATA_W - 1) / 2;
  localparam logic signed [SUM_W-1:0] ONE = 1;

  logic signed [SUM_W-1:0] sum_q;

  always_comb begin
    sum_next = sum_q;
    if (bit_valid) begin
      sum_next = bit_val ? (sum_q + ONE) : (sum_q - ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (bit_valid) begin
      sum_q <= sum_next;
    end
  end

  assign sum = sum_q;

  AST_SUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> ((sum_q == $past(sum_q) + ONE) || (sum_q == $past(sum_q) - ONE))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> (sum_q == $past(sum_q))); // R8
  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_q <= BIT_LIM) && (sum_q >= -BIT_LIM)); // R5
  AST_BND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> ((sum_next <= BND_LIM) && (sum_next >= -BND_LIM))); // R5

endmodule

// File: rtl/dcb_clk_lane.sv
module dcb_clk_lane
  import dcb_pkg::*;
#(
  parameter int FRAME_W = 9,
  parameter int PH_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            active,
  input  logic [PH_W-1:0] phase,
  output logic            lane
);
  localparam int HI_SHORT = FRAME_W / 2;
  localparam int HI_LONG  = FRAME_W - HI_SHORT;
  localparam logic signed [PH_W+1:0] CONE = 1;

  hi_sel_e         sel_q;
  hi_sel_e         sel_d;
  logic [PH_W-1:0] hi_len;

  assign sel_d  = (sel_q == HI_LONG_SEL) ? HI_SHORT_SEL : HI_LONG_SEL;
  assign hi_len = (sel_q == HI_LONG_SEL) ? PH_W'(HI_LONG) : PH_W'(HI_SHORT);
  assign lane   = active && (phase < hi_len);

  // Reset to long so the first frame takes the short form
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= HI_LONG_SEL;
    end else if (accept) begin
      sel_q <= sel_d;
    end
  end

  // Clock-lane tally kept for the bound check only
  logic signed [PH_W+1:0] csum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csum_q <= '0;
    end else if (active) begin
      csum_q <= lane ? (csum_q + CONE) : (csum_q - CONE);
    end
  end

  AST_CLK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (csum_q <= HI_LONG) && (csum_q >= -HI_LONG)); // R7

endmodule

// File: rtl/dcb_lane_enc.sv
module dcb_lane_enc #(
  parameter int DATA_W = 7,
  parameter int SUM_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    word_stb,
  input  logic [DATA_W-1:0]       word_data,
  output logic                    ser_out,
  output logic                    clk_lane_out,
  output logic signed [SUM_W-1:0] run_sum
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int PH_W    = $clog2(FRAME_W);
  localparam logic [PH_W-1:0] LAST = PH_W'(FRAME_W - 1);
  localparam logic [PH_W-1:0] PONE = 1;

  // Reset: asynchronous assert, synchronous release
  logic rst_meta_q;
  logic rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic               active_q, active_d;
  logic [PH_W-1:0]    phase_q, phase_d;
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [FRAME_W-1:0] frame_w;
  logic               inv_w;
  logic               on_last;
  logic               accept;
  logic               step_en;
  logic signed [SUM_W-1:0] sum_next;

  assign on_last = active_q && (phase_q == LAST);
  assign accept  = word_stb && (!active_q || on_last);
  assign step_en = accept || active_q;
  assign ser_out = active_q && sreg_q[FRAME_W-1];

  dcb_disparity_acc #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .bit_valid(active_q),
    .bit_val  (ser_out),
    .boundary (accept),
    .sum      (run_sum),
    .sum_next (sum_next)
  );

  dcb_word_enc #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_enc (
    .data    (word_data),
    .bnd_sum (sum_next),
    .frame   (frame_w),
    .inverted(inv_w)
  );

  dcb_clk_lane #(.FRAME_W(FRAME_W), .PH_W(PH_W)) u_clk (
    .clk   (clk),
    .rst_n (rst_core_n),
    .accept(accept),
    .active(active_q),
    .phase (phase_q),
    .lane  (clk_lane_out)
  );

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    sreg_d   = sreg_q;
    if (accept) begin
      active_d = 1'b1;
      phase_d  = '0;
      sreg_d   = frame_w;
    end else if (active_q) begin
      if (on_last) begin
        active_d = 1'b0;
      end else begin
        phase_d = phase_q + PONE;
        sreg_d  = {sreg_q[FRAME_W-2:0], sreg_q[FRAME_W-1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      sreg_q   <= '0;
    end else if (step_en) begin
      active_q <= active_d;
      phase_q  <= phase_d;
      sreg_q   <= sreg_d;
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_core_n)
    active_q |-> (phase_q <= LAST)); // R6
  AST_FLAGS_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_core_n)
    on_last |-> (sreg_q[FRAME_W-1] != sreg_q[FRAME_W-2])); // R2
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (accept && (sum_next == 0)) |-> !inv_w); // R3

endmodule

// File: tb/dcb_lane_enc_bench.sv
`timescale 1ns/1ps
module dcb_lane_enc_bench;
  logic              clk;
  logic              rst_n;
  logic              word_stb;
  logic [6:0]        word_data;
  logic              ser_out;
  logic              clk_lane_out;
  logic signed [5:0] run_sum;

  dcb_lane_enc u_dcb_lane_enc (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_stb    (word_stb),
    .word_data   (word_data),
    .ser_out     (ser_out),
    .clk_lane_out(clk_lane_out),
    .run_sum     (run_sum)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int         n_chk;
  int         n_fail;
  int         exp_sum;
  int         max_sum;
  bit         exp_long;
  logic [6:0] wq [0:511];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    word_stb  = 1'b0;
    word_data = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    chk(ser_out == 1'b0 && clk_lane_out == 1'b0, "R1 lanes low in reset", int'(ser_out), 0);
    chk(int'(run_sum) == 0, "R1 tally zero in reset", int'(run_sum), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_sum  = 0;
    max_sum  = 0;
    exp_long = 1'b0;
  endtask

  // Streams wq[0..n-1] back to back; optional mid-frame strobe noise
  task automatic send_words(input int n, input bit noise);
    for (int i = 0; i < n; i++) begin
      int         sb;
      int         ones;
      bit         inv;
      int         hi;
      logic [8:0] fr;
      logic [8:0] rx;
      logic [6:0] rec;
      word_stb  = 1'b1;
      word_data = wq[i];
      sb   = exp_sum;
      ones = $countones(wq[i]);
      inv  = ((sb > 0) && (ones > 3)) || ((sb < 0) && (ones < 4));
      fr   = {inv, (inv ? ~wq[i] : wq[i]), ~inv};
      hi   = exp_long ? 5 : 4;
      for (int k = 0; k < 9; k++) begin
        @(negedge clk);
        if (k == 0) begin
          word_stb = 1'b0;
          chk(ser_out == fr[8], "R3 marker A reflects inversion", int'(ser_out), int'(fr[8]));
        end
        chk(ser_out == fr[8-k], "R2 frame bit order", int'(ser_out), int'(fr[8-k]));
        chk(clk_lane_out == (k < hi), "R7 clock lane pattern", int'(clk_lane_out), int'(k < hi));
        chk(int'(run_sum) == exp_sum, "R4 running tally", int'(run_sum), exp_sum);
        chk(int'(run_sum) <= 11 && int'(run_sum) >= -11, "R5 tally bound", int'(run_sum), 11);
        if (k == 0) begin
          chk(int'(run_sum) <= 7 && int'(run_sum) >= -7, "R5 boundary bound", int'(run_sum), 7);
        end
        if (int'(run_sum) > max_sum) max_sum = int'(run_sum);
        rx[8-k] = ser_out;
        exp_sum = exp_sum + (fr[8-k] ? 1 : -1);
        if (noise && k == 3) begin
          word_stb  = 1'b1;
          word_data = ~wq[i];
        end
        if (noise && k == 4) word_stb = 1'b0;
      end
      rec = rx[8] ? ~rx[7:1] : rx[7:1];
      chk(rx[8] != rx[0], "R9 markers complementary", int'(rx[0]), int'(~rx[8]));
      chk(rec == wq[i], "R9 word recovered", int'(rec), int'(wq[i]));
      exp_long = ~exp_long;
    end
    @(negedge clk);
    chk(ser_out == 1'b0 && clk_lane_out == 1'b0, "R8 lanes low when idle", int'(ser_out), 0);
    chk(int'(run_sum) == exp_sum, "R8 tally after stream", int'(run_sum), exp_sum);
  endtask

  task automatic t_reset();
    do_reset();
    for (int c = 0; c < 3; c++) begin
      chk(ser_out == 1'b0 && clk_lane_out == 1'b0, "R1 lanes low after release", int'(clk_lane_out), 0);
      chk(int'(run_sum) == 0, "R1 tally zero after release", int'(run_sum), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_zero_sum();
    do_reset();
    wq[0] = 7'b1100000;
    wq[1] = 7'b1111100;
    send_words(2, 1'b0);
  endtask

  task automatic t_peak();
    do_reset();
    wq[0] = 7'b1111111;
    wq[1] = 7'b0001111;
    wq[2] = 7'b0000000;
    send_words(3, 1'b0);
    chk(max_sum == 11, "R5 peak tally reached", max_sum, 11);
  endtask

  task automatic t_noise();
    do_reset();
    wq[0] = 7'b1010011;
    wq[1] = 7'b0111000;
    wq[2] = 7'b1110001;
    send_words(3, 1'b1);
  endtask

  task automatic t_idle_gap();
    int held;
    do_reset();
    wq[0] = 7'b1011110;
    wq[1] = 7'b0000101;
    send_words(2, 1'b0);
    held = int'(run_sum);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(ser_out == 1'b0 && clk_lane_out == 1'b0, "R8 idle lanes", int'(ser_out), 0);
      chk(int'(run_sum) == held, "R8 idle tally hold", int'(run_sum), held);
    end
    wq[0] = 7'b0110110;
    wq[1] = 7'b1001000;
    wq[2] = 7'b1111011;
    send_words(3, 1'b0);
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 400; i++) wq[i] = 7'($urandom);
    send_words(400, 1'b0);
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    t_reset();
    t_zero_sum();
    t_peak();
    t_noise();
    t_idle_gap();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule